// File: doc/BRIEF.md
# Receive Descriptor Write-Back Engine

This block moves received Ethernet frames from a byte stream into host memory using a ring of 32-byte receive descriptors. For each frame it first collects a short head of bytes. Once the frame is known to be long enough, it reads the descriptor at the current ring pointer through a simple 32-bit memory master. If the host owns nothing there, the frame is thrown away. Otherwise the bytes are written packed into the buffer that the descriptor names. The engine then writes a status word back into the descriptor, which returns it to the host, and it proposes the next ring pointer.

The host keeps the ring base and the current pointer. It loads the pointer the engine offers whenever the pointer-write strobe pulses. The engine also sorts each stored frame by destination address into broadcast or multicast, and keeps wrapping counters for stored bytes, stored frames, broadcast frames and multicast frames.

Top module: `rxdesc_engine`

## Requirements
- R1: While no frame is in progress and `rx_en` is low, `s_ready` stays 0 and no byte is consumed. The enable is sampled only when a frame starts.
- R2: A frame shorter than 12 bytes causes no memory access. It produces a one-cycle `rx_done`, leaves `ptr_we` low and changes no counter.
- R3: A descriptor whose word 0 has bit 31 clear causes the rest of the frame to be consumed and discarded. No memory write follows. A one-cycle `buf_unavail` is raised after the last byte, and the pointer and counters do not change.
- R4: Frame byte k goes to byte address (word 2 of the descriptor, with its low two bits ignored) + k, packed little-endian into 32-bit words. The last word enables only its valid byte lanes, so memory beyond the frame is untouched.
- R5: For a stored frame of L bytes, descriptor word 0 is rewritten as ((L + 4) << 16) | 0x300. This clears bit 31, which returns ownership to the host.
- R6: On a stored frame, `ptr_we` and `rx_done` pulse together for one cycle. `ptr_next` is `ring_base` when bit 15 of descriptor word 1 (the buffer-size half-word) is set, and `cur_ptr` + 32 otherwise.
- R7: A stored frame whose first six bytes are all 0xFF counts in `cnt_bcast`. A stored frame whose byte 0 has bit 0 set and that is not broadcast counts in `cnt_mcast`.
- R8: Each stored frame adds 1 to `cnt_frames` and L + 4 to `cnt_bytes`. All counters are CNT_W bits wide and wrap modulo 2^CNT_W.
- R9: Once `mem_req` is raised, it stays high with a stable address, direction and write data until the cycle in which `mem_ack` is high.
- R10: `rx_done` and `buf_unavail` are single-cycle pulses and are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rx_en | input | 1 | Receive enable, sampled at frame start |
| ring_base | input | 32 | Address of the first descriptor in the ring |
| cur_ptr | input | 32 | Address of the current descriptor, held by the host |
| s_valid | input | 1 | Frame byte valid |
| s_data | input | 8 | Frame byte |
| s_last | input | 1 | Marks the final byte of a frame |
| s_ready | output | 1 | Byte accepted when high together with s_valid |
| mem_req | output | 1 | Memory request |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_addr | output | 32 | Byte address, word aligned |
| mem_wdata | output | 32 | Write data |
| mem_be | output | 4 | Write byte enables |
| mem_ack | input | 1 | Completes the current request; read data is valid with it |
| mem_rdata | input | 32 | Read data |
| rx_done | output | 1 | Pulse: frame stored or runt dropped |
| buf_unavail | output | 1 | Pulse: frame discarded because no descriptor was owned |
| ptr_we | output | 1 | Pulse: load ptr_next into the host pointer |
| ptr_next | output | 32 | Next descriptor address |
| cnt_bytes | output | CNT_W | Stored bytes including 4 per frame |
| cnt_frames | output | CNT_W | Stored frames |
| cnt_bcast | output | CNT_W | Stored broadcast frames |
| cnt_mcast | output | CNT_W | Stored multicast frames |

## Verification
The bench instantiates the engine with CNT_W = 6. With that width, the byte counter wraps many times over the sweep and the frame counter wraps at least once, so the modulo behaviour is exercised against arithmetic expectations. Every frame length from 1 to 48 bytes is sent twice over a four-entry ring. This covers every runt length, every final-word lane count, the wrap descriptor, all four destination patterns including an all-ones-but-one address, and a repeating pattern of descriptors the host does not own. The default hold depth of 12 bytes is kept, so the runt boundary is checked at 11 and 12 bytes.

// File: rtl/rxdesc_pkg.sv
package rxdesc_pkg;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_HEAD,
    ST_DRD,
    ST_HFL,
    ST_BODY,
    ST_WR,
    ST_STAT,
    ST_DRAIN
  } rxd_state_e;

  // byte enables covering lanes 0..lane
  function automatic logic [3:0] lane_mask(input logic [1:0] lane);
    case (lane)
      2'd0:    lane_mask = 4'b0001;
      2'd1:    lane_mask = 4'b0011;
      2'd2:    lane_mask = 4'b0111;
      default: lane_mask = 4'b1111;
    endcase
  endfunction

endpackage

// File: rtl/rxdesc_fsm.sv
module rxdesc_fsm
  import rxdesc_pkg::*;
#(
  parameter int LEN_W      = 16,
  parameter int RUNT_BYTES = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             rx_en,
  input  logic [31:0]      cur_ptr,
  input  logic             s_valid,
  input  logic [7:0]       s_data,
  input  logic             s_last,
  output logic             s_ready,
  output logic             mem_req,
  output logic             mem_we,
  output logic [31:0]      mem_addr,
  output logic [31:0]      mem_wdata,
  output logic [3:0]       mem_be,
  input  logic             mem_ack,
  input  logic [31:0]      mem_rdata,
  output logic             commit,
  output logic             runt_ev,
  output logic             unav_ev,
  output logic             wrap_flag,
  output logic [LEN_W-1:0] frame_len,
  output logic [31:0]      dst_lo,
  output logic [15:0]      dst_hi
);

  localparam int HOLD_N = RUNT_BYTES / 4;
  localparam int HIDX_W = (HOLD_N > 1) ? $clog2(HOLD_N) : 1;
  localparam int WIDX_W = LEN_W - 2;

  rxd_state_e        st_q, st_d;
  logic [LEN_W-1:0]  len_q, len_d;
  logic [31:0]       pack_q, pack_d, pack_ins;
  logic [31:0]       hold_q [HOLD_N];
  logic [31:0]       hold_d [HOLD_N];
  logic [1:0]        rdi_q, rdi_d;
  logic              own_q, own_d;
  logic              wrap_q, wrap_d;
  logic [31:0]       buf_q, buf_d;
  logic [WIDX_W-1:0] widx_q, widx_d;
  logic [31:0]       wdat_q, wdat_d;
  logic [3:0]        be_q, be_d;
  logic              lastf_q, lastf_d;
  logic [1:0]        lane;
  logic [15:0]       len_fld;
  logic [31:0]       word_off;

  assign lane      = len_q[1:0];
  assign len_fld   = 16'(len_q) + 16'd4;
  assign word_off  = {{(32-LEN_W){1'b0}}, widx_q, 2'b00};
  assign wrap_flag = wrap_q;
  assign frame_len = len_q;
  assign dst_lo    = hold_q[0];
  assign dst_hi    = hold_q[1][15:0];

  always_comb begin
    pack_ins = pack_q;
    pack_ins[{lane, 3'b000} +: 8] = s_data;
  end

  // next-state process
  always_comb begin
    st_d    = st_q;
    len_d   = len_q;
    pack_d  = pack_q;
    for (int i = 0; i < HOLD_N; i++) hold_d[i] = hold_q[i];
    rdi_d   = rdi_q;
    own_d   = own_q;
    wrap_d  = wrap_q;
    buf_d   = buf_q;
    widx_d  = widx_q;
    wdat_d  = wdat_q;
    be_d    = be_q;
    lastf_d = lastf_q;
    s_ready   = 1'b0;
    mem_req   = 1'b0;
    mem_we    = 1'b0;
    mem_addr  = 32'd0;
    mem_wdata = 32'd0;
    mem_be    = 4'd0;
    commit    = 1'b0;
    runt_ev   = 1'b0;
    unav_ev   = 1'b0;

    case (st_q)
      ST_IDLE: begin
        if (rx_en && s_valid) begin
          st_d   = ST_HEAD;
          len_d  = '0;
          pack_d = '0;
        end
      end

      ST_HEAD: begin
        s_ready = 1'b1;
        if (s_valid) begin
          len_d  = len_q + 1'b1;
          pack_d = pack_ins;
          if (lane == 2'd3) hold_d[len_q[HIDX_W+1:2]] = pack_ins;
          if (len_q == LEN_W'(RUNT_BYTES - 1)) begin
            lastf_d = s_last;
            rdi_d   = 2'd0;
            st_d    = ST_DRD;
          end else if (s_last) begin
            runt_ev = 1'b1;
            st_d    = ST_IDLE;
          end
        end
      end

      ST_DRD: begin
        mem_req  = 1'b1;
        mem_addr = cur_ptr + {28'd0, rdi_q, 2'b00};
        if (mem_ack) begin
          rdi_d = rdi_q + 2'd1;
          case (rdi_q)
            2'd0:    own_d  = mem_rdata[31];
            2'd1:    wrap_d = mem_rdata[15];
            default: buf_d  = mem_rdata & 32'hFFFF_FFFC;
          endcase
          if (rdi_q == 2'd2) begin
            if (!own_q) begin
              if (lastf_q) begin
                unav_ev = 1'b1;
                st_d    = ST_IDLE;
              end else begin
                st_d = ST_DRAIN;
              end
            end else begin
              widx_d = '0;
              st_d   = ST_HFL;
            end
          end
        end
      end

      ST_HFL: begin
        mem_req   = 1'b1;
        mem_we    = 1'b1;
        mem_addr  = buf_q + word_off;
        mem_wdata = hold_q[widx_q[HIDX_W-1:0]];
        mem_be    = 4'hF;
        if (mem_ack) begin
          widx_d = widx_q + 1'b1;
          pack_d = '0;
          if (widx_q == WIDX_W'(HOLD_N - 1)) st_d = lastf_q ? ST_STAT : ST_BODY;
        end
      end

      ST_BODY: begin
        s_ready = 1'b1;
        if (s_valid) begin
          len_d = len_q + 1'b1;
          if (lane == 2'd3 || s_last) begin
            wdat_d  = pack_ins;
            be_d    = lane_mask(lane);
            widx_d  = len_q[LEN_W-1:2];
            lastf_d = s_last;
            pack_d  = '0;
            st_d    = ST_WR;
          end else begin
            pack_d = pack_ins;
          end
        end
      end

      ST_WR: begin
        mem_req   = 1'b1;
        mem_we    = 1'b1;
        mem_addr  = buf_q + word_off;
        mem_wdata = wdat_q;
        mem_be    = be_q;
        if (mem_ack) st_d = lastf_q ? ST_STAT : ST_BODY;
      end

      ST_STAT: begin
        mem_req   = 1'b1;
        mem_we    = 1'b1;
        mem_addr  = cur_ptr;
        mem_wdata = {len_fld, 16'h0300};
        mem_be    = 4'hF;
        if (mem_ack) begin
          commit = 1'b1;
          st_d   = ST_IDLE;
        end
      end

      ST_DRAIN: begin
        s_ready = 1'b1;
        if (s_valid && s_last) begin
          unav_ev = 1'b1;
          st_d    = ST_IDLE;
        end
      end

      default: st_d = ST_IDLE;
    endcase
  end

  // register process
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= ST_IDLE;
      len_q   <= '0;
      pack_q  <= '0;
      for (int i = 0; i < HOLD_N; i++) hold_q[i] <= '0;
      rdi_q   <= '0;
      own_q   <= 1'b0;
      wrap_q  <= 1'b0;
      buf_q   <= '0;
      widx_q  <= '0;
      wdat_q  <= '0;
      be_q    <= '0;
      lastf_q <= 1'b0;
    end else begin
      st_q    <= st_d;
      len_q   <= len_d;
      pack_q  <= pack_d;
      for (int i = 0; i < HOLD_N; i++) hold_q[i] <= hold_d[i];
      rdi_q   <= rdi_d;
      own_q   <= own_d;
      wrap_q  <= wrap_d;
      buf_q   <= buf_d;
      widx_q  <= widx_d;
      wdat_q  <= wdat_d;
      be_q    <= be_d;
      lastf_q <= lastf_d;
    end
  end

endmodule

// File: rtl/rxdesc_classify.sv
module rxdesc_classify (
  input  logic [31:0] dst_lo,
  input  logic [15:0] dst_hi,
  output logic        is_bc,
  output logic        is_mc
);

  always_comb begin
    is_bc = (dst_lo == 32'hFFFF_FFFF) && (dst_hi == 16'hFFFF);
    is_mc = dst_lo[0] && !is_bc;
  end

endmodule

// File: rtl/rxdesc_stats.sv
module rxdesc_stats #(
  parameter int CNT_W = 64,
  parameter int LEN_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             commit,
  input  logic [LEN_W-1:0] frame_len,
  input  logic             is_bc,
  input  logic             is_mc,
  output logic [CNT_W-1:0] cnt_bytes,
  output logic [CNT_W-1:0] cnt_frames,
  output logic [CNT_W-1:0] cnt_bcast,
  output logic [CNT_W-1:0] cnt_mcast
);

  localparam int SUM_W = (CNT_W > LEN_W + 1) ? CNT_W : LEN_W + 1;
  localparam int NCNT  = 3;

  logic [SUM_W-1:0] add_ext;
  logic [CNT_W-1:0] bytes_q;
  logic [CNT_W-1:0] bytes_d;
  logic [NCNT-1:0]  inc;
  logic [CNT_W-1:0] ctr_q [NCNT];

  assign add_ext = SUM_W'(frame_len) + SUM_W'(4);
  assign bytes_d = bytes_q + add_ext[CNT_W-1:0];
  assign inc     = {commit & is_mc, commit & is_bc, commit};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      bytes_q <= '0;
    else if (commit) bytes_q <= bytes_d;
  end

  for (genvar g = 0; g < NCNT; g++) begin : g_ctr
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      ctr_q[g] <= '0;
      else if (inc[g]) ctr_q[g] <= ctr_q[g] + 1'b1;
    end
  end

  assign cnt_bytes  = bytes_q;
  assign cnt_frames = ctr_q[0];
  assign cnt_bcast  = ctr_q[1];
  assign cnt_mcast  = ctr_q[2];

endmodule

// File: rtl/rxdesc_engine.sv
module rxdesc_engine #(
  parameter int CNT_W      = 64,
  parameter int LEN_W      = 16,
  parameter int RUNT_BYTES = 12,
  parameter int DESC_BYTES = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             rx_en,
  input  logic [31:0]      ring_base,
  input  logic [31:0]      cur_ptr,
  input  logic             s_valid,
  input  logic [7:0]       s_data,
  input  logic             s_last,
  output logic             s_ready,
  output logic             mem_req,
  output logic             mem_we,
  output logic [31:0]      mem_addr,
  output logic [31:0]      mem_wdata,
  output logic [3:0]       mem_be,
  input  logic             mem_ack,
  input  logic [31:0]      mem_rdata,
  output logic             rx_done,
  output logic             buf_unavail,
  output logic             ptr_we,
  output logic [31:0]      ptr_next,
  output logic [CNT_W-1:0] cnt_bytes,
  output logic [CNT_W-1:0] cnt_frames,
  output logic [CNT_W-1:0] cnt_bcast,
  output logic [CNT_W-1:0] cnt_mcast
);

  localparam logic [31:0] STEP = 32'(DESC_BYTES);

  logic             commit, runt_ev, unav_ev, wrap_flag;
  logic [LEN_W-1:0] frame_len;
  logic [31:0]      dst_lo;
  logic [15:0]      dst_hi;
  logic             is_bc, is_mc;

  rxdesc_fsm #(.LEN_W(LEN_W), .RUNT_BYTES(RUNT_BYTES)) u_fsm (
    .clk(clk), .rst_n(rst_n), .rx_en(rx_en), .cur_ptr(cur_ptr),
    .s_valid(s_valid), .s_data(s_data), .s_last(s_last), .s_ready(s_ready),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_be(mem_be), .mem_ack(mem_ack),
    .mem_rdata(mem_rdata), .commit(commit), .runt_ev(runt_ev),
    .unav_ev(unav_ev), .wrap_flag(wrap_flag), .frame_len(frame_len),
    .dst_lo(dst_lo), .dst_hi(dst_hi)
  );

  rxdesc_classify u_cls (
    .dst_lo(dst_lo), .dst_hi(dst_hi), .is_bc(is_bc), .is_mc(is_mc)
  );

  rxdesc_stats #(.CNT_W(CNT_W), .LEN_W(LEN_W)) u_stats (
    .clk(clk), .rst_n(rst_n), .commit(commit), .frame_len(frame_len),
    .is_bc(is_bc), .is_mc(is_mc), .cnt_bytes(cnt_bytes),
    .cnt_frames(cnt_frames), .cnt_bcast(cnt_bcast), .cnt_mcast(cnt_mcast)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx_done     <= 1'b0;
      buf_unavail <= 1'b0;
      ptr_we      <= 1'b0;
    end else begin
      rx_done     <= commit | runt_ev;
      buf_unavail <= unav_ev;
      ptr_we      <= commit;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      ptr_next <= '0;
    else if (commit) ptr_next <= wrap_flag ? ring_base : cur_ptr + STEP;
  end

endmodule

// File: rtl/rxdesc_chk.sv
module rxdesc_chk #(
  parameter int CNT_W      = 64,
  parameter int DESC_BYTES = 32
) (
  input logic             clk,
  input logic             rst_n,
  input logic [31:0]      ring_base,
  input logic [31:0]      cur_ptr,
  input logic             mem_req,
  input logic             mem_we,
  input logic [31:0]      mem_addr,
  input logic [31:0]      mem_wdata,
  input logic [3:0]       mem_be,
  input logic             mem_ack,
  input logic             rx_done,
  input logic             buf_unavail,
  input logic             ptr_we,
  input logic [31:0]      ptr_next,
  input logic [CNT_W-1:0] cnt_frames
);

  AST_REQ_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_we) && $stable(mem_wdata))); // R9

  AST_BE_CONTIG: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && mem_we) |-> (mem_be == 4'h1 || mem_be == 4'h3 || mem_be == 4'h7 || mem_be == 4'hF)); // R4

  AST_PULSE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(rx_done && buf_unavail)); // R10

  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    rx_done |=> !rx_done); // R10

  AST_PTR_WITH_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    ptr_we |-> rx_done); // R6

  AST_PTR_TARGET: assert property (@(posedge clk) disable iff (!rst_n)
    ptr_we |-> (ptr_next == ring_base || ptr_next == cur_ptr + 32'(DESC_BYTES))); // R6

  AST_FRAME_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    ptr_we |-> (cnt_frames == $past(cnt_frames) + 1'b1)); // R8

  AST_FRAME_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !ptr_we |-> $stable(cnt_frames)); // R8

endmodule

bind rxdesc_engine rxdesc_chk #(.CNT_W(CNT_W), .DESC_BYTES(DESC_BYTES)) u_chk (
  .clk(clk), .rst_n(rst_n), .ring_base(ring_base), .cur_ptr(cur_ptr),
  .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
  .mem_wdata(mem_wdata), .mem_be(mem_be), .mem_ack(mem_ack),
  .rx_done(rx_done), .buf_unavail(buf_unavail), .ptr_we(ptr_we),
  .ptr_next(ptr_next), .cnt_frames(cnt_frames)
);

// File: tb/rxdesc_engine_bench.sv
module rxdesc_engine_bench;

  localparam int CW = 6;
  localparam logic [31:0] BASE = 32'h100;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic rx_en = 1'b0;
  logic s_valid = 1'b0;
  logic [7:0] s_data = 8'd0;
  logic s_last = 1'b0;
  logic s_ready;
  logic mem_req, mem_we, mem_ack;
  logic [31:0] mem_addr, mem_wdata, mem_rdata;
  logic [3:0] mem_be;
  logic rx_done, buf_unavail, ptr_we;
  logic [31:0] ptr_next;
  logic [31:0] host_ptr;
  logic [CW-1:0] cnt_bytes, cnt_frames, cnt_bcast, cnt_mcast;

  logic [7:0] mem [0:2047];
  logic hs = 1'b0;
  int done_cnt = 0;
  int unav_cnt = 0;
  int total = 0;
  int bad = 0;
  int req_cnt = 0;
  logic [CW-1:0] e_bytes = '0, e_frames = '0, e_bc = '0, e_mc = '0;

  always #10 clk = ~clk;

  rxdesc_engine #(.CNT_W(CW)) u_rxdesc_engine (
    .clk(clk), .rst_n(rst_n), .rx_en(rx_en), .ring_base(BASE),
    .cur_ptr(host_ptr), .s_valid(s_valid), .s_data(s_data), .s_last(s_last),
    .s_ready(s_ready), .mem_req(mem_req), .mem_we(mem_we),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_be(mem_be),
    .mem_ack(mem_ack), .mem_rdata(mem_rdata), .rx_done(rx_done),
    .buf_unavail(buf_unavail), .ptr_we(ptr_we), .ptr_next(ptr_next),
    .cnt_bytes(cnt_bytes), .cnt_frames(cnt_frames),
    .cnt_bcast(cnt_bcast), .cnt_mcast(cnt_mcast)
  );

  function automatic logic [31:0] rd32(input logic [31:0] a);
    logic [10:0] b;
    b = a[10:0];
    rd32 = {mem[b + 11'd3], mem[b + 11'd2], mem[b + 11'd1], mem[b]};
  endfunction

  assign mem_rdata = rd32(mem_addr);

  // memory model: acknowledge one cycle after a request
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) mem_ack <= 1'b0;
    else        mem_ack <= mem_req & ~mem_ack;
  end

  always @(posedge clk) begin
    if (mem_req && mem_we && mem_ack)
      for (int b = 0; b < 4; b++)
        if (mem_be[b]) mem[mem_addr[10:0] + 11'(b)] <= mem_wdata[8*b +: 8];
  end

  always @(posedge clk) begin
    hs <= s_valid & s_ready;
    if (rst_n && rx_done) done_cnt <= done_cnt + 1;
    if (rst_n && buf_unavail) unav_cnt <= unav_cnt + 1;
    if (rst_n && mem_req) req_cnt <= req_cnt + 1;
  end

  // host pointer register
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n)      host_ptr <= BASE;
    else if (ptr_we) host_ptr <= ptr_next;
  end

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wr32(input logic [31:0] a, input logic [31:0] v);
    for (int b = 0; b < 4; b++) mem[a[10:0] + 11'(b)] = v[8*b +: 8];
  endtask

  function automatic logic [7:0] fbyte(input int len, input int kind, input int i);
    if (i < 6) begin
      case (kind)
        0:       fbyte = (i == 0) ? 8'h02 : 8'(8'h10 + i);
        1:       fbyte = 8'hFF;
        2:       fbyte = (i == 0) ? 8'h33 : 8'(8'h20 + i);
        default: fbyte = (i == 5) ? 8'hFE : 8'hFF;
      endcase
    end else begin
      fbyte = 8'(len * 7 + i);
    end
  endfunction

  task automatic send(input int len, input int kind);
    for (int i = 0; i < len; i++) begin
      s_valid = 1'b1;
      s_data  = fbyte(len, kind, i);
      s_last  = (i == len - 1);
      do @(negedge clk); while (!hs);
    end
    s_valid = 1'b0;
    s_last  = 1'b0;
  endtask

  task automatic run_frame(input int len, input int kind, input bit own);
    int idx, d0, u0, mism, tail;
    logic [31:0] p0, bufa, expp, w0;
    bit wrap;
    p0   = host_ptr;
    idx  = int'((p0 - BASE) >> 5);
    bufa = 32'h400 + 32'(idx) * 32'h100;
    wrap = (idx == 3);
    for (int i = 0; i < 256; i++) mem[bufa[10:0] + 11'(i)] = 8'hEE;
    wr32(p0, own ? 32'h8000_0000 : 32'h0000_0000);
    wr32(p0 + 4, {16'h0, wrap, 15'h0100});
    wr32(p0 + 8, bufa);
    d0 = done_cnt;
    u0 = unav_cnt;
    send(len, kind);
    repeat (30) @(negedge clk);
    w0 = rd32(p0);
    if (len < 12) begin
      chk(done_cnt == d0 + 1, "R2 runt done", done_cnt, d0 + 1);
      chk(w0 == 32'h8000_0000 || !own, "R2 desc untouched", w0, 32'h8000_0000);
      chk(mem[bufa[10:0]] == 8'hEE, "R2 buffer untouched", mem[bufa[10:0]], 8'hEE);
      chk(host_ptr == p0, "R2 pointer kept", host_ptr, p0);
    end else if (!own) begin
      chk(unav_cnt == u0 + 1, "R3 unavailable pulse", unav_cnt, u0 + 1);
      chk(done_cnt == d0, "R3 no done", done_cnt, d0);
      chk(mem[bufa[10:0]] == 8'hEE, "R3 buffer untouched", mem[bufa[10:0]], 8'hEE);
      chk(host_ptr == p0, "R3 pointer kept", host_ptr, p0);
    end else begin
      chk(done_cnt == d0 + 1 && unav_cnt == u0, "R10 done only", done_cnt, d0 + 1);
      chk(w0 == {16'(len + 4), 16'h0300}, "R5 status word", w0, {16'(len + 4), 16'h0300});
      mism = 0;
      for (int i = 0; i < len; i++)
        if (mem[bufa[10:0] + 11'(i)] != fbyte(len, kind, i)) mism++;
      chk(mism == 0, "R4 payload bytes", mism, 0);
      tail = 0;
      for (int i = len; i < len + 8; i++)
        if (mem[bufa[10:0] + 11'(i)] != 8'hEE) tail++;
      chk(tail == 0, "R4 bytes past frame", tail, 0);
      expp = wrap ? BASE : p0 + 32'd32;
      chk(host_ptr == expp, "R6 next pointer", host_ptr, expp);
      e_bytes  = e_bytes + CW'(len + 4);
      e_frames = e_frames + 1'b1;
      if (kind == 1) e_bc = e_bc + 1'b1;
      if (kind >= 2) e_mc = e_mc + 1'b1;
    end
    chk(cnt_bytes == e_bytes, "R8 byte counter", cnt_bytes, e_bytes);
    chk(cnt_frames == e_frames, "R8 frame counter", cnt_frames, e_frames);
    chk(cnt_bcast == e_bc, "R7 broadcast counter", cnt_bcast, e_bc);
    chk(cnt_mcast == e_mc, "R7 multicast counter", cnt_mcast, e_mc);
  endtask

  initial begin
    int r0;
    for (int i = 0; i < 2048; i++) mem[i] = 8'h00;
    repeat (3) @(negedge clk);
    chk(s_ready == 1'b0 && mem_req == 1'b0, "reset idle", {s_ready, mem_req}, 0);
    chk(rx_done == 1'b0 && ptr_we == 1'b0 && cnt_frames == '0, "reset outputs", cnt_frames, 0);
    rst_n = 1'b1;
    @(negedge clk);
    // R1: disabled receiver consumes nothing
    r0 = req_cnt;
    s_valid = 1'b1;
    s_data  = 8'h02;
    for (int i = 0; i < 8; i++) begin
      @(negedge clk);
      chk(s_ready == 1'b0 && !hs, "R1 ready low while disabled", s_ready, 0);
    end
    chk(req_cnt == r0, "R1 no memory access", req_cnt, r0);
    s_valid = 1'b0;
    rx_en   = 1'b1;
    @(negedge clk);
    for (int pass = 0; pass < 2; pass++)
      for (int len = 1; len <= 48; len++)
        run_frame(len, (len + pass) % 4, ((len + pass) % 7) != 3);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog actual=hung expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule